// File: doc/BRIEF.md
# Programmable Parallel Token Matcher

This block watches a stream of 8-bit tokens, at most one per clock, and reports in every result which of sixteen programmable search keys the token equals. There is no frame or string boundary: each token is judged on its own, and results emerge in the same order after a fixed two-cycle delay. Several keys may hit the same token, so the result is a vector with one flag per key, together with the index of the lowest-numbered hitting key and a bit that says whether any key hit.

Each key is not kept as a stored value with a comparator. Instead it lives in two tiny one-bit lookup tables, one addressed by the upper half of the token and one by the lower half. A key hits when both table reads return one. Loading a key is a sixteen-cycle sweep that writes every table address. During the sweep a per-bit care mask is folded into the written contents, so a bit marked "don't care" costs nothing in the match path. Every slot has its own sweep counter. Start strobes for different keys on consecutive cycles therefore run as overlapping, staggered sweeps, and all sixteen keys load in 31 cycles.

Top module: `token_matcher`

## Requirements
- R1: After reset `prog_busy`, `hit_valid`, `hit_any` and every bit of `hit_flags` are 0, all tables hold 0, and no token hits any key until that key has been loaded.
- R2: A token presented with `tok_valid` high at a rising edge produces its result (`hit_valid` = 1 with `hit_flags`, `hit_any`, `hit_idx`) exactly two rising edges later. Tokens may arrive on every cycle. When `hit_valid` is 0, `hit_flags` and `hit_any` are 0.
- R3: Flag k of a result is 1 exactly when key k has been loaded and, for every bit position where that key's care mask is 1, the token bit equals the key bit. Any number of flags may be 1 at once.
- R4: A care-mask bit of 0 makes that token bit a wildcard for that key. A mask of all zeros matches every token.
- R5: A `prog_start` accepted at a rising edge latches `prog_key`, `prog_value` and `prog_mask`. `prog_busy` is high for exactly the 16 cycles that follow, and the new key takes effect for tokens whose lookup cycle follows the sweep. Loading a key replaces its previous value.
- R6: Start strobes for different keys on consecutive cycles run as overlapping sweeps. Loading all 16 keys back to back keeps `prog_busy` high for 31 cycles.
- R7: A `prog_start` naming a key whose sweep is still running is ignored. The first value stays in force and the sweep length does not change.
- R8: Every flag of a result is forced to 0 if `prog_busy` was high in the cycle after its token was sampled (the lookup cycle).
- R9: `hit_any` is 1 exactly when at least one flag is 1, and `hit_idx` then gives the lowest-numbered key whose flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | Token present this cycle |
| tok_data | input | 8 | Token value |
| prog_start | input | 1 | Begin loading the key named by `prog_key` |
| prog_key | input | 4 | Key slot to load |
| prog_value | input | 8 | Key value to load |
| prog_mask | input | 8 | Care mask, 1 = compare that bit, 0 = wildcard |
| prog_busy | output | 1 | At least one key sweep is running |
| hit_valid | output | 1 | A token result is on the hit outputs |
| hit_flags | output | 16 | One flag per key, bit k for key k |
| hit_any | output | 1 | At least one flag is set |
| hit_idx | output | 4 | Lowest-numbered key with its flag set |

## Verification
Each token's result is due on the second rising edge after it is sampled. The bench stamps every expected result with that cycle number when the driver pushes it into the scoreboard. The monitor rejects a result that arrives in any other cycle. Load timing is measured by counting the cycles in which `prog_busy` is high: 16 after a single start and 31 after sixteen staggered starts. Suppression is exercised by sending tokens on the very edge a sweep starts and throughout it, with all-zero results expected for each of them.

// File: rtl/tm_pkg.sv
// Shared constants and the table-fill rule for the token matcher.
// Assumes tokens are split into 4-bit slices, each addressing a 16-entry table.
package tm_pkg;

    localparam int TM_NIB_W = 4;

    // Table bit for address a: 1 when every cared-for bit of a equals the key slice
    function automatic logic tm_fill_bit(
        input logic [TM_NIB_W-1:0] addr,
        input logic [TM_NIB_W-1:0] key_slice,
        input logic [TM_NIB_W-1:0] care_slice
    );
        return ((addr ^ key_slice) & care_slice) == '0;
    endfunction

endpackage

// File: rtl/tm_key_slot.sv
// One key slot: per-slice 1-bit lookup tables plus its own fill sequencer.
// A load strobe while idle latches value and care mask, then writes one table
// address per cycle for 2**TM_NIB_W cycles. A load strobe while sweeping is dropped.
// The hit output is a pure table read of the supplied token.
module tm_key_slot
    import tm_pkg::*;
#(
    parameter int TOK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TOK_W-1:0] load_val,
    input  logic [TOK_W-1:0] load_care,
    input  logic [TOK_W-1:0] look_tok,
    output logic             sweeping,
    output logic             key_hit
);
    localparam int SLICES = TOK_W / TM_NIB_W;
    localparam int DEPTH  = 1 << TM_NIB_W;

    logic [TM_NIB_W-1:0]          addr;
    logic [TOK_W-1:0]             val_q;
    logic [TOK_W-1:0]             care_q;
    logic [SLICES-1:0][DEPTH-1:0] tbl;

    // Fill sequencer: accept a load when idle, then write one address per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweeping <= 1'b0;
            addr     <= '0;
            val_q    <= '0;
            care_q   <= '0;
            tbl      <= '0;
        end else if (load && !sweeping) begin
            sweeping <= 1'b1;
            addr     <= '0;
            val_q    <= load_val;
            care_q   <= load_care;
        end else if (sweeping) begin
            for (int s = 0; s < SLICES; s++) begin
                tbl[s][addr] <= tm_fill_bit(addr,
                                            val_q[s*TM_NIB_W +: TM_NIB_W],
                                            care_q[s*TM_NIB_W +: TM_NIB_W]);
            end
            addr <= addr + 1'b1;
            if (addr == TM_NIB_W'(DEPTH - 1)) begin
                sweeping <= 1'b0;
            end
        end
    end

    // Match path: AND of one table read per token slice
    always_comb begin
        key_hit = 1'b1;
        for (int s = 0; s < SLICES; s++) begin
            key_hit = key_hit & tbl[s][look_tok[s*TM_NIB_W +: TM_NIB_W]];
        end
    end

    // R7
    restart_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweeping && load) |=> ($stable(val_q) && $stable(care_q)));

endmodule

// File: rtl/tm_lowest_enc.sv
// Priority encoder: index of the lowest set flag, plus an any-set bit.
// Assumes IW is wide enough to hold N-1.
module tm_lowest_enc #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  flags,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top down so the lowest set flag wins
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/token_matcher.sv
// Parallel token matcher: every accepted token is looked up in all key slots
// at once. Stage 1 registers the token, the lookup runs in the next cycle,
// and stage 2 registers the flags and the encoded index. Results are
// zeroed while any slot is sweeping. Assumes TOK_W is a multiple of 4.
module token_matcher #(
    parameter int NUM_KEYS = 16,
    parameter int TOK_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tok_valid,
    input  logic [TOK_W-1:0]            tok_data,
    input  logic                        prog_start,
    input  logic [$clog2(NUM_KEYS)-1:0] prog_key,
    input  logic [TOK_W-1:0]            prog_value,
    input  logic [TOK_W-1:0]            prog_mask,
    output logic                        prog_busy,
    output logic                        hit_valid,
    output logic [NUM_KEYS-1:0]         hit_flags,
    output logic                        hit_any,
    output logic [$clog2(NUM_KEYS)-1:0] hit_idx
);
    localparam int KEY_IW = $clog2(NUM_KEYS);

    logic                tok_vld_q;
    logic [TOK_W-1:0]    tok_q;
    logic [NUM_KEYS-1:0] slot_sweep;
    logic [NUM_KEYS-1:0] slot_hit;
    logic [NUM_KEYS-1:0] flags_nx;
    logic [KEY_IW-1:0]   idx_nx;
    logic                any_nx;

    // Stage 1: capture the incoming token
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_vld_q <= 1'b0;
            tok_q     <= '0;
        end else begin
            tok_vld_q <= tok_valid;
            tok_q     <= tok_data;
        end
    end

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_slot
        tm_key_slot #(.TOK_W(TOK_W)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (prog_start && (prog_key == KEY_IW'(k))),
            .load_val (prog_value),
            .load_care(prog_mask),
            .look_tok (tok_q),
            .sweeping (slot_sweep[k]),
            .key_hit  (slot_hit[k])
        );
    end

    assign prog_busy = |slot_sweep;

    // Gate lookups: no token or a running sweep gives an empty result
    always_comb begin
        flags_nx = (tok_vld_q && !prog_busy) ? slot_hit : '0;
    end

    tm_lowest_enc #(.N(NUM_KEYS), .IW(KEY_IW)) i_enc (
        .flags(flags_nx),
        .idx  (idx_nx),
        .any  (any_nx)
    );

    // Stage 2: register the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            hit_flags <= '0;
            hit_any   <= 1'b0;
            hit_idx   <= '0;
        end else begin
            hit_valid <= tok_vld_q;
            hit_flags <= flags_nx;
            hit_any   <= any_nx;
            hit_idx   <= idx_nx;
        end
    end

    // R8
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prog_busy) |-> (hit_flags == '0));

    // R2
    idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |-> ((hit_flags == '0) && !hit_any));

    // R9
    any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any == (hit_flags != '0));

    // R9
    idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> (hit_flags[hit_idx] &&
                     ((hit_flags & ((NUM_KEYS'(1) << hit_idx) - NUM_KEYS'(1))) == '0)));

endmodule

// File: tb/test_token_matcher.sv
// Scoreboard bench: the driver pushes expected results stamped with their due
// cycle, and the monitor pops and compares them at each falling edge.
module test_token_matcher;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tok_valid;
    logic [7:0]  tok_data;
    logic        prog_start;
    logic [3:0]  prog_key;
    logic [7:0]  prog_value;
    logic [7:0]  prog_mask;
    logic        prog_busy;
    logic        hit_valid;
    logic [15:0] hit_flags;
    logic        hit_any;
    logic [3:0]  hit_idx;

    always #5 clk = ~clk;

    token_matcher i_token_matcher (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_data(tok_data),
        .prog_start(prog_start), .prog_key(prog_key), .prog_value(prog_value),
        .prog_mask(prog_mask), .prog_busy(prog_busy), .hit_valid(hit_valid),
        .hit_flags(hit_flags), .hit_any(hit_any), .hit_idx(hit_idx)
    );

    typedef struct {
        logic [15:0] flags;
        int          due;
        string       req;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    int         busy_cnt = 0;
    logic [7:0] m_val  [16];
    logic [7:0] m_care [16];
    bit         m_on   [16];

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (prog_busy) busy_cnt++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [7:0] t);
        logic [15:0] f = '0;
        for (int k = 0; k < 16; k++)
            f[k] = m_on[k] && (((t ^ m_val[k]) & m_care[k]) == 8'h00);
        return f;
    endfunction

    task automatic send_tok(input logic [7:0] t, input bit sup, input string req);
        exp_t e;
        @(negedge clk);
        tok_valid = 1'b1;
        tok_data  = t;
        e.flags = sup ? 16'h0 : model(t);
        e.due   = cyc + 2;
        e.req   = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            tok_valid = 1'b0;
        end
    endtask

    task automatic prog_issue(input logic [3:0] k, input logic [7:0] v,
                              input logic [7:0] c, input bit upd);
        @(negedge clk);
        prog_start = 1'b1;
        prog_key   = k;
        prog_value = v;
        prog_mask  = c;
        if (upd) begin
            m_val[k] = v; m_care[k] = c; m_on[k] = 1'b1;
        end
    endtask

    task automatic prog_clear();
        @(negedge clk);
        prog_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (prog_busy) @(negedge clk);
    endtask

    // Monitor: pop the expected result and compare flags, any, index and timing
    always @(negedge clk) begin
        if (rst_n && hit_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected result", 32'(hit_flags), 0);
            end else begin
                exp_t e;
                logic       ea;
                logic [3:0] ei;
                e = sb.pop_front();
                ea = 1'b0;
                ei = 4'h0;
                for (int k = 15; k >= 0; k--)
                    if (e.flags[k]) begin ea = 1'b1; ei = 4'(k); end
                check(cyc == e.due, "R2", "result cycle", 32'(cyc), 32'(e.due));
                check(hit_flags == e.flags, e.req, "flags", 32'(hit_flags), 32'(e.flags));
                check(hit_any == ea, "R9", "any", 32'(hit_any), 32'(ea));
                if (ea) check(hit_idx == ei, "R9", "idx", 32'(hit_idx), 32'(ei));
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            m_val[k] = '0; m_care[k] = '0; m_on[k] = 1'b0;
        end
        rst_n = 1'b0; tok_valid = 1'b0; tok_data = '0;
        prog_start = 1'b0; prog_key = '0; prog_value = '0; prog_mask = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(prog_busy == 1'b0, "R1", "busy", 32'(prog_busy), 0);
        check(hit_valid == 1'b0, "R1", "valid", 32'(hit_valid), 0);
        check(hit_flags == '0, "R1", "flags", 32'(hit_flags), 0);
        rst_n = 1'b1;
        // R1: nothing loaded yet, so nothing hits (not even token 0)
        send_tok(8'h00, 1'b0, "R1");
        send_tok(8'h41, 1'b0, "R1");
        idle(3);

        // R5: single load, busy for 16 cycles
        busy_cnt = 0;
        prog_issue(4'd3, 8'h41, 8'hFF, 1'b1);
        prog_clear();
        wait_idle();
        check(busy_cnt == 16, "R5", "busy cycles", 32'(busy_cnt), 16);
        send_tok(8'h41, 1'b0, "R3");
        send_tok(8'h42, 1'b0, "R3");
        idle(3);

        // R4: wildcard low nibble on key 5, wildcard high nibble on key 9
        prog_issue(4'd5, 8'h40, 8'hF0, 1'b1);
        prog_clear();
        wait_idle();
        prog_issue(4'd9, 8'h01, 8'h0F, 1'b1);
        prog_clear();
        wait_idle();
        // R3 multiple flags, R9 lowest index, R2 back-to-back stream
        send_tok(8'h41, 1'b0, "R3");
        send_tok(8'h51, 1'b0, "R4");
        send_tok(8'h4A, 1'b0, "R4");
        send_tok(8'h3C, 1'b0, "R3");
        send_tok(8'h91, 1'b0, "R4");
        idle(3);

        // R6: sixteen staggered loads finish in 31 cycles
        busy_cnt = 0;
        for (int k = 0; k < 16; k++)
            prog_issue(4'(k), 8'(8'h80 + k), 8'hFF, 1'b1);
        prog_clear();
        wait_idle();
        check(busy_cnt == 31, "R6", "busy cycles", 32'(busy_cnt), 31);
        for (int k = 0; k < 16; k++)
            send_tok(8'(8'h80 + k), 1'b0, "R6");
        send_tok(8'h41, 1'b0, "R5");
        idle(3);

        // R7: second start for a sweeping key is dropped
        busy_cnt = 0;
        prog_issue(4'd2, 8'h10, 8'hFF, 1'b1);
        prog_issue(4'd2, 8'h20, 8'hFF, 1'b0);
        prog_clear();
        wait_idle();
        check(busy_cnt == 16, "R7", "busy cycles", 32'(busy_cnt), 16);
        send_tok(8'h10, 1'b0, "R7");
        send_tok(8'h20, 1'b0, "R7");
        send_tok(8'h82, 1'b0, "R5");
        idle(3);

        // R8: tokens on the start edge and during the sweep yield empty results
        @(negedge clk);
        prog_start = 1'b1; prog_key = 4'd4; prog_value = 8'h33; prog_mask = 8'hFF;
        tok_valid = 1'b1; tok_data = 8'h81;
        begin
            exp_t e;
            e.flags = '0; e.due = cyc + 2; e.req = "R8";
            sb.push_back(e);
        end
        m_val[4] = 8'h33; m_care[4] = 8'hFF; m_on[4] = 1'b1;
        for (int i = 0; i < 10; i++) begin
            send_tok(8'h81, 1'b1, "R8");
            prog_start = 1'b0;
        end
        idle(1);
        wait_idle();
        idle(1);
        send_tok(8'h33, 1'b0, "R8");
        send_tok(8'h81, 1'b0, "R8");

        // R4: all-wildcard key matches everything
        idle(2);
        prog_issue(4'd15, 8'h00, 8'h00, 1'b1);
        prog_clear();
        wait_idle();
        send_tok(8'h8F, 1'b0, "R4");
        send_tok(8'hC7, 1'b0, "R4");
        idle(5);
        check(sb.size() == 0, "R2", "pending results", 32'(sb.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule